// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one memory-to-memory copy channel that takes its work from a chain of descriptors stored in memory. Each descriptor is four consecutive words. Word 0 is the source address, word 1 is the destination address, word 2 is the link to the next descriptor and word 3 is the word count. The channel reads a descriptor and copies the requested number of words, one read followed by one write each. It then moves to the linked descriptor, and continues until it reaches a descriptor whose link carries the end-of-list flag.

Software controls the channel through four word-wide registers, selected by a 2-bit address. Offset 0 is the control register, offset 1 is the status register, offset 2 is the descriptor pointer and offset 3 is the remaining-count register. To start a chain, software loads the pointer and then raises the run bit. An abort request parks the channel in a halted state. Dropping the run bit returns the channel to idle. One level interrupt reports enabled completion and error conditions. All addresses are word addresses. A descriptor sits on a 4-word boundary, so it is 32-byte aligned for 64-bit words.

Top module: `dma_link_chan`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low and `mem_req` is low.
- R2: A 0-to-1 write of the run bit (control bit 0) while idle makes the channel read the descriptor words at the pointer with its two low bits cleared, in the order +0, +1, +2, +3. Every memory request is made while status bit 0 (busy) is set.
- R3: For a count N, the channel reads source word i and then writes it to destination word i, for i = 0 to N-1 in ascending order.
- R4: When the link word has bit 0 clear, the channel continues with the descriptor at the link with its two low bits cleared (bit 1 is ignored). The pointer register then reads that aligned address. After a chain, the count register reads 0.
- R5: When the last word of a descriptor whose link has bit 0 set has been written, busy clears. Status bit 2 (end of list) and status bit 3 (descriptor done) are set. The run bit still reads 1.
- R6: Writing 1 to the run bit while it already reads 1 starts nothing. A new chain needs the run bit to be written 0 and then 1.
- R7: Status bits 2 to 5 are sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: A descriptor with a count of 0 sets status bit 4 (programming error) and ends the chain without any data access. The count register then reads 0.
- R9: A count greater than MAX_COUNT sets status bit 4 and ends the chain without any data access.
- R10: An error response on any memory access sets status bit 5 (transfer error), clears busy and ends the chain.
- R11: Writing control bit 1 (abort, reads 0) while busy sets status bit 1 (halted), keeps busy set and stops all memory requests. Writing the run bit to 0 then clears both busy and halted.
- R12: `irq` equals (control bit 2 AND (status bit 4 OR status bit 5)) OR (control bit 3 AND status bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 control, 1 status, 2 pointer, 3 count) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| irq | output | 1 | Level interrupt |

## Verification
The copy engine is exercised with a single descriptor and with a two-descriptor chain whose link word also carries the ignored bit 1. These two patterns separate a correct link-following step from one that mishandles the low link bits or restarts at the wrong address. Counts of 0 and of MAX_COUNT+1 are checked by counting memory reads, which distinguishes a rejected descriptor from one that moves data. An error injected on the second source read shows whether the chain stops after exactly one word. Abort, the repeated-run write and the interrupt enables are each tried against known status contents.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int DATA_W = 32;

    // control register bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_ABORT  = 1;
    localparam int CB_ERR_IE = 2;
    localparam int CB_EOL_IE = 3;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_PTR  = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_FETCH,
        EN_READ,
        EN_WRITE,
        EN_HALT
    } eng_state_e;

    typedef struct packed {
        logic eol_ie;
        logic err_ie;
        logic run;
    } ctrl_t;

    // sticky status flags; packed so flags map to status bits [5:2]
    typedef struct packed {
        logic xfer_err;
        logic prog_err;
        logic desc_done;
        logic end_list;
    } flags_t;

    function automatic logic [DATA_W-1:0] ctrl_image(ctrl_t c);
        return {{(DATA_W-4){1'b0}}, c.eol_ie, c.err_ie, 1'b0, c.run};
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [5:0]        wbits,
    input  logic [DATA_W-1:0] ptr_ext,
    input  logic [DATA_W-1:0] cnt_ext,
    input  logic              busy,
    input  logic              halted,
    input  flags_t            ev,
    output logic              go,
    output logic              stop,
    output logic              abort,
    output logic              ptr_we,
    output flags_t            flags_q,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq
);

    ctrl_t ctrl_q;
    logic  wr_ctrl;
    logic  wr_stat;

    assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
    assign wr_stat = cfg_we && (cfg_addr == REG_STAT);
    assign ptr_we  = cfg_we && (cfg_addr == REG_PTR);

    assign go    = wr_ctrl && wbits[CB_RUN] && !ctrl_q.run && !busy;
    assign stop  = wr_ctrl && !wbits[CB_RUN] && ctrl_q.run;
    assign abort = wr_ctrl && wbits[CB_ABORT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run    <= wbits[CB_RUN];
                ctrl_q.err_ie <= wbits[CB_ERR_IE];
                ctrl_q.eol_ie <= wbits[CB_EOL_IE];
            end
            flags_q <= (flags_q & ~(wr_stat ? flags_t'(wbits[5:2]) : flags_t'(4'b0))) | ev;
        end
    end

    always_comb begin
        case (reg_sel_e'(cfg_addr))
            REG_CTRL: cfg_rdata = ctrl_image(ctrl_q);
            REG_STAT: cfg_rdata = {{(DATA_W-6){1'b0}}, flags_q, halted, busy};
            REG_PTR:  cfg_rdata = ptr_ext;
            default:  cfg_rdata = cnt_ext;
        endcase
    end

    assign irq = (ctrl_q.err_ie && (flags_q.prog_err || flags_q.xfer_err))
              || (ctrl_q.eol_ie && flags_q.end_list);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_COUNT = 16,
    localparam int CNT_W    = $clog2(MAX_COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              stop,
    input  logic              abort,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              halted,
    output flags_t            ev,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [CNT_W-1:0]  cnt_q
);

    eng_state_e        state;
    logic [1:0]        fidx;
    logic [ADDR_W-1:0] src_q, dst_q, link_q;
    logic [DATA_W-1:0] hold_q;
    logic              hit, bad, last_word, bad_count;
    logic              unused_link;

    assign unused_link = link_q[1];
    assign busy      = (state != EN_IDLE);
    assign halted    = (state == EN_HALT);
    assign hit       = mem_req && mem_ack && !mem_err;
    assign bad       = mem_req && mem_err;
    assign last_word = (cnt_q == CNT_W'(1));
    assign bad_count = (mem_rdata == '0) || (mem_rdata > DATA_W'(MAX_COUNT));

    always_comb begin
        mem_req   = (state == EN_FETCH) || (state == EN_READ) || (state == EN_WRITE);
        mem_we    = (state == EN_WRITE);
        mem_wdata = hold_q;
        case (state)
            EN_FETCH: mem_addr = {ptr_q[ADDR_W-1:2], fidx};
            EN_READ:  mem_addr = src_q;
            EN_WRITE: mem_addr = dst_q;
            default:  mem_addr = '0;
        endcase
    end

    // completion events, visible to the status register in the same cycle
    always_comb begin
        ev = '0;
        if (!stop && !abort) begin
            if (bad) begin
                ev.xfer_err = 1'b1;
            end else if (hit) begin
                if (state == EN_FETCH && fidx == 2'd3 && bad_count)
                    ev.prog_err = 1'b1;
                if (state == EN_WRITE && last_word) begin
                    ev.desc_done = 1'b1;
                    ev.end_list  = link_q[0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= EN_IDLE;
            fidx   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
            hold_q <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else if (stop && state != EN_IDLE) begin
            state <= EN_IDLE;
        end else if (abort && state != EN_IDLE) begin
            state <= EN_HALT;
        end else begin
            case (state)
                EN_IDLE: begin
                    if (ptr_we) ptr_q <= ptr_wdata;
                    if (go) begin
                        state <= EN_FETCH;
                        fidx  <= '0;
                    end
                end
                EN_FETCH: begin
                    if (bad) begin
                        state <= EN_IDLE;
                    end else if (hit) begin
                        fidx <= fidx + 2'd1;
                        case (fidx)
                            2'd0: src_q  <= mem_rdata[ADDR_W-1:0];
                            2'd1: dst_q  <= mem_rdata[ADDR_W-1:0];
                            2'd2: link_q <= mem_rdata[ADDR_W-1:0];
                            default: begin
                                if (bad_count) begin
                                    cnt_q <= '0;
                                    state <= EN_IDLE;
                                end else begin
                                    cnt_q <= mem_rdata[CNT_W-1:0];
                                    state <= EN_READ;
                                end
                            end
                        endcase
                    end
                end
                EN_READ: begin
                    if (bad) begin
                        state <= EN_IDLE;
                    end else if (hit) begin
                        hold_q <= mem_rdata;
                        state  <= EN_WRITE;
                    end
                end
                EN_WRITE: begin
                    if (bad) begin
                        state <= EN_IDLE;
                    end else if (hit) begin
                        src_q <= src_q + ADDR_W'(1);
                        dst_q <= dst_q + ADDR_W'(1);
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (!last_word) begin
                            state <= EN_READ;
                        end else if (link_q[0]) begin
                            state <= EN_IDLE;
                        end else begin
                            ptr_q <= {link_q[ADDR_W-1:2], 2'b00};
                            fidx  <= '0;
                            state <= EN_FETCH;
                        end
                    end
                end
                default: state <= EN_HALT;
            endcase
        end
    end

endmodule

// File: rtl/dma_link_chan.sv
module dma_link_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);

    localparam int CNT_W = $clog2(MAX_COUNT + 1);

    logic              go, stop, abort, ptr_we, busy, halted;
    flags_t            ev, flags_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ev_eol;
    logic [3:0]        flag_bits;
    logic              unused_cfg;

    assign unused_cfg = &{1'b0, cfg_wdata};
    assign ev_eol     = ev.end_list;
    assign flag_bits  = flags_q;

    dma_chan_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .wbits     (cfg_wdata[5:0]),
        .ptr_ext   (DATA_W'(ptr_q)),
        .cnt_ext   (DATA_W'(cnt_q)),
        .busy      (busy),
        .halted    (halted),
        .ev        (ev),
        .go        (go),
        .stop      (stop),
        .abort     (abort),
        .ptr_we    (ptr_we),
        .flags_q   (flags_q),
        .cfg_rdata (cfg_rdata),
        .irq       (irq)
    );

    dma_chan_engine #(
        .ADDR_W    (ADDR_W),
        .MAX_COUNT (MAX_COUNT)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .stop      (stop),
        .abort     (abort),
        .ptr_we    (ptr_we),
        .ptr_wdata (cfg_wdata[ADDR_W-1:0]),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .busy      (busy),
        .halted    (halted),
        .ev        (ev),
        .ptr_q     (ptr_q),
        .cnt_q     (cnt_q)
    );

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       halted,
    input logic       mem_req,
    input logic       mem_err,
    input logic       abort,
    input logic       stop,
    input logic       ev_eol,
    input logic       irq,
    input logic [3:0] flag_bits
);

    // R2: memory is only touched while the channel reports busy
    assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R11: a halted channel stays busy and issues no requests
    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        halted |-> (busy && !mem_req));

    // R10: an error response ends the chain on the next cycle
    assert_err_stop_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err && !abort && !stop) |=> !busy);

    // R5: the end-of-list event leaves the channel idle
    assert_eol_stop_R5: assert property (@(posedge clk) disable iff (rst)
        ev_eol |=> !busy);

    // R12: the interrupt needs at least one sticky flag behind it
    assert_irq_src_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|flag_bits));

endmodule

bind dma_link_chan dma_chan_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .halted    (halted),
    .mem_req   (mem_req),
    .mem_err   (mem_err),
    .abort     (abort),
    .stop      (stop),
    .ev_eol    (ev_eol),
    .irq       (irq),
    .flag_bits (flag_bits)
);

// File: tb/dma_link_chan_bench.sv
module dma_link_chan_bench;

    localparam int AW  = 16;
    localparam int MAX = 16;

    logic        clk, rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        irq;

    logic [31:0] bmem [256];
    logic        ld_en;
    logic [7:0]  ld_a;
    logic [31:0] ld_d;
    logic        err_en;
    logic [AW-1:0] err_addr;
    logic        log_clr;
    logic [AW-1:0] rlog [32];
    int          log_n, wr_n;
    int          n_chk, n_err;

    dma_link_chan #(.ADDR_W(AW), .MAX_COUNT(MAX)) u_dma_link_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign mem_ack   = mem_req && !mem_err;
    assign mem_rdata = bmem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (ld_en)
            bmem[ld_a] <= ld_d;
        else if (mem_req && mem_we && !mem_err)
            bmem[mem_addr[7:0]] <= mem_wdata;
        if (log_clr) begin
            log_n <= 0;
            wr_n  <= 0;
        end else if (mem_req && !mem_err) begin
            if (!mem_we && log_n < 32) begin
                rlog[log_n] <= mem_addr;
                log_n <= log_n + 1;
            end
            if (mem_we) wr_n <= wr_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic clear_log;
        log_clr = 1'b1;
        @(posedge clk); #1;
        log_clr = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0] base, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] nx, input logic [31:0] c);
        poke(base, s);
        poke(base + 8'd1, d);
        poke(base + 8'd2, nx);
        poke(base + 8'd3, c);
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            cfg_read(2'd1, s);
            if (!s[0]) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic launch(input logic [31:0] ptr, input logic [31:0] ctrl);
        cfg_write(2'd1, 32'h3C);
        clear_log();
        cfg_write(2'd0, ctrl & ~32'h1);
        cfg_write(2'd2, ptr);
        cfg_write(2'd0, ctrl);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int r = 0; r < 4; r++) begin
            cfg_read(r[1:0], v);
            check("R1 register zero", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 mem_req low", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            poke(8'h40 + 8'(i), 32'hA000_0000 + i);
            poke(8'h80 + 8'(i), 32'hDEAD_0000);
        end
        put_desc(8'h10, 32'h40, 32'h80, 32'h1, 32'd4);
        launch(32'h10, 32'hD);
        wait_idle();
        for (int i = 0; i < 4; i++) check("R2 fetch order", 32'(rlog[i]), 32'h10 + i);
        check("R3 first data read at source", 32'(rlog[4]), 32'h40);
        for (int i = 0; i < 4; i++) check("R3 copied word", bmem[8'h80 + 8'(i)], 32'hA000_0000 + i);
        cfg_read(2'd1, v);
        check("R5 status after end of list", v, 32'h0C);
        cfg_read(2'd0, v);
        check("R5 run bit stays set", v, 32'hD);
        check("R12 irq on end of list", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        cfg_write(2'd1, 32'h04);
        cfg_read(2'd1, v);
        check("R7 clear end-of-list only", v, 32'h08);
        check("R12 irq drops with flag", {31'b0, irq}, 32'h0);
        cfg_write(2'd1, 32'h00);
        cfg_read(2'd1, v);
        check("R7 zero write keeps flag", v, 32'h08);
        cfg_write(2'd1, 32'h08);
        cfg_read(2'd1, v);
        check("R7 clear descriptor-done", v, 32'h00);
    endtask

    task automatic t_rerun;
        logic [31:0] v;
        clear_log();
        cfg_write(2'd0, 32'hD);
        repeat (6) @(posedge clk);
        #1;
        cfg_read(2'd1, v);
        check("R6 repeated run write stays idle", v, 32'h0);
        check("R6 no memory reads", 32'(log_n), 32'h0);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        poke(8'h48, 32'hB000_0001);
        poke(8'h49, 32'hB000_0002);
        for (int i = 0; i < 3; i++) poke(8'h4C + 8'(i), 32'hC000_0000 + i);
        put_desc(8'h20, 32'h48, 32'h90, 32'h32, 32'd2);
        put_desc(8'h30, 32'h4C, 32'hA0, 32'h1, 32'd3);
        launch(32'h20, 32'hD);
        wait_idle();
        check("R2 chain first fetch", 32'(rlog[0]), 32'h20);
        check("R2 chain last field", 32'(rlog[3]), 32'h23);
        check("R4 second descriptor fetched aligned", 32'(rlog[6]), 32'h30);
        check("R3 chain word a0", bmem[8'h90], 32'hB000_0001);
        check("R3 chain word a1", bmem[8'h91], 32'hB000_0002);
        check("R4 chain word b2", bmem[8'hA2], 32'hC000_0002);
        cfg_read(2'd2, v);
        check("R4 pointer follows link", v, 32'h30);
        cfg_read(2'd3, v);
        check("R4 count drained", v, 32'h0);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        logic seen;
        put_desc(8'h14, 32'h40, 32'hC0, 32'h1, 32'd12);
        launch(32'h14, 32'hD);
        repeat (5) @(posedge clk);
        #1;
        cfg_write(2'd0, 32'hF);
        cfg_read(2'd1, v);
        check("R11 halted and busy", v, 32'h03);
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            if (mem_req) seen = 1'b1;
        end
        check("R11 no requests while halted", {31'b0, seen}, 32'h0);
        check("R11 copy cut short", {31'b0, wr_n < 12}, 32'h1);
        cfg_write(2'd0, 32'hC);
        cfg_read(2'd1, v);
        check("R11 run clear releases", v, 32'h00);
        cfg_read(2'd3, v);
        check("R11 count left nonzero", {31'b0, v != 0}, 32'h1);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        put_desc(8'h38, 32'h40, 32'hE0, 32'h1, 32'd0);
        poke(8'hE0, 32'h5555_5555);
        launch(32'h38, 32'h1);
        wait_idle();
        cfg_read(2'd1, v);
        check("R8 programming error", v, 32'h10);
        cfg_read(2'd3, v);
        check("R8 count reads zero", v, 32'h0);
        check("R8 only descriptor read", 32'(log_n), 32'h4);
        check("R8 destination untouched", bmem[8'hE0], 32'h5555_5555);
        check("R12 irq masked", {31'b0, irq}, 32'h0);
        cfg_write(2'd0, 32'h4);
        check("R12 irq after error enable", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_over;
        logic [31:0] v;
        put_desc(8'h3C, 32'h40, 32'hE0, 32'h1, 32'(MAX + 1));
        launch(32'h3C, 32'h5);
        wait_idle();
        cfg_read(2'd1, v);
        check("R9 oversize count flagged", v, 32'h10);
        check("R9 no data reads", 32'(log_n), 32'h4);
        check("R9 destination untouched", bmem[8'hE0], 32'h5555_5555);
    endtask

    task automatic t_err;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) poke(8'hF0 + 8'(i), 32'h7777_7777);
        put_desc(8'h18, 32'h40, 32'hF0, 32'h1, 32'd4);
        err_en = 1'b1;
        err_addr = AW'(16'h41);
        launch(32'h18, 32'h5);
        wait_idle();
        err_en = 1'b0;
        cfg_read(2'd1, v);
        check("R10 transfer error, idle", v, 32'h20);
        check("R10 first word moved", bmem[8'hF0], 32'hA000_0000);
        check("R10 second word not moved", bmem[8'hF1], 32'h7777_7777);
        check("R12 irq on transfer error", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        n_chk = 0; n_err = 0;
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
        ld_en = 1'b0; ld_a = '0; ld_d = '0; err_en = 1'b0; err_addr = '0;
        log_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        log_clr = 1'b0;
        t_reset();
        t_single();
        t_w1c();
        t_rerun();
        t_chain();
        t_abort();
        t_zero();
        t_over();
        t_err();
        report();
    end

endmodule